// File: doc/BRIEF.md
# Real-Time Clock Interrupt Status and Alarm Match

This block keeps the three event flags of a real-time clock: periodic tick, alarm match and update done. It also produces the interrupt request from those flags and their enables. The alarm comparator checks the current seconds, minutes and hours against three alarm bytes on every update pulse. An alarm byte whose two top bits are both one matches any value, so software can ask for an alarm every day, hour, minute or second.

Software reads the status byte with a level read strobe. The first cycle of the strobe freezes the byte that is presented and clears the live flags. Events that arrive while the strobe is high are parked and become visible when the strobe drops. The interrupt pin is open-drain. It is modelled as a pull-down enable that is high only while the combined request is active.

Top module: `rtc_irq_ctl`

## Requirements
- R1: The status byte carries the request summary in bit 7, the periodic flag in bit 6, the alarm flag in bit 5 and the update flag in bit 4. Bits 3 to 0 are always zero.
- R2: Outside a read, the request summary equals (periodic & periodic-enable) | (alarm & alarm-enable) | (update & update-enable), and `irq_pull_o` equals that summary.
- R3: Flags are set whatever their enables hold. Enabling an interrupt whose flag is already set raises `irq_pull_o` in the cycle after the configuration write.
- R4: The first clock edge with `rd_i` high captures the status byte and clears all flags. The captured value stays on `status_o` for as long as `rd_i` is high, and `irq_pull_o` is low during the read.
- R5: Events that arrive during a read, including one in the same cycle as the read's first edge, are held. They appear on `status_o` after the first edge with `rd_i` low.
- R6: An alarm byte with bits 7:6 equal to 2'b11 (0xC0 to 0xFF) matches any time byte. Any other alarm byte matches only an equal time byte, so 0xBF and 0x80 are not wildcards.
- R7: The alarm flag is set only on an update pulse, and only when all three alarm bytes match the time bytes present in that cycle.
- R8: Each update pulse sets the update flag, and each periodic pulse sets the periodic flag, one cycle later.
- R9: An active-low reset clears all three flags and all three enables, and releases `irq_pull_o`.
- R10: A configuration write with `cfg_set_i` high clears the update enable, whatever `cfg_uie_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| per_i | input | 1 | Periodic tick pulse |
| upd_i | input | 1 | Update-done pulse |
| sec_i | input | 8 | Current seconds byte |
| min_i | input | 8 | Current minutes byte |
| hr_i | input | 8 | Current hours byte |
| alm_sec_i | input | 8 | Seconds alarm byte |
| alm_min_i | input | 8 | Minutes alarm byte |
| alm_hr_i | input | 8 | Hours alarm byte |
| cfg_wr_i | input | 1 | Load the enables from the cfg inputs |
| cfg_pie_i | input | 1 | Periodic interrupt enable value |
| cfg_aie_i | input | 1 | Alarm interrupt enable value |
| cfg_uie_i | input | 1 | Update interrupt enable value |
| cfg_set_i | input | 1 | Time-setting mode; forces the update enable to zero |
| rd_i | input | 1 | Status read strobe, level |
| status_o | output | 8 | Status byte |
| irq_pull_o | output | 1 | Pull-down enable for the open-drain request pin |

## Verification
Two things can fall in the same cycle: an incoming event pulse and the start or end of a status read. The bench provokes this by raising the periodic pulse on the very edge that starts a read, and again in the middle of a longer read. It judges the result by checking three things: the frozen byte leaves out the event, the pin stays released during the read, and the flag shows up right after the strobe drops. An update pulse that sets the update and alarm flags together is also compared against a table of alarm patterns that includes wildcard and near-wildcard bytes.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int BYTE_W   = 8;
    localparam int N_FIELDS = 3;
    localparam int WILD_W   = 2;

    typedef struct packed {
        logic pf;
        logic af;
        logic uf;
    } flags_t;

    typedef struct packed {
        logic pie;
        logic aie;
        logic uie;
    } en_t;

    function automatic logic req_of(flags_t f, en_t e);
        return (f.pf & e.pie) | (f.af & e.aie) | (f.uf & e.uie);
    endfunction

    function automatic logic [7:0] byte_of(flags_t f, en_t e);
        return {req_of(f, e), f.pf, f.af, f.uf, 4'b0000};
    endfunction
endpackage

// File: rtl/rtc_byte_match.sv
module rtc_byte_match #(
    parameter int W  = 8,
    parameter int WB = 2
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] alm_i,
    output logic         hit_o
);
    logic wild;
    always_comb begin
        wild  = &alm_i[W-1 -: WB];
        hit_o = wild | (alm_i == cur_i);
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int W  = 8,
    parameter int N  = 3,
    parameter int WB = 2
) (
    input  logic [N-1:0][W-1:0] cur_i,
    input  logic [N-1:0][W-1:0] alm_i,
    output logic                all_o
);
    logic [N-1:0] hit;
    for (genvar g = 0; g < N; g++) begin : g_field
        rtc_byte_match #(.W(W), .WB(WB)) u_m (
            .cur_i (cur_i[g]),
            .alm_i (alm_i[g]),
            .hit_o (hit[g])
        );
    end
    assign all_o = &hit;
endmodule

// File: rtl/rtc_irq_ctl.sv
module rtc_irq_ctl
    import rtc_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        per_i,
    input  logic        upd_i,
    input  logic [7:0]  sec_i,
    input  logic [7:0]  min_i,
    input  logic [7:0]  hr_i,
    input  logic [7:0]  alm_sec_i,
    input  logic [7:0]  alm_min_i,
    input  logic [7:0]  alm_hr_i,
    input  logic        cfg_wr_i,
    input  logic        cfg_pie_i,
    input  logic        cfg_aie_i,
    input  logic        cfg_uie_i,
    input  logic        cfg_set_i,
    input  logic        rd_i,
    output logic [7:0]  status_o,
    output logic        irq_pull_o
);
    typedef struct packed {
        flags_t     flags;
        flags_t     pend;
        en_t        en;
        logic [7:0] snap;
        logic       in_read;
    } state_t;

    state_t st_d, st_q;

    logic [N_FIELDS-1:0][BYTE_W-1:0] cur, alm;
    logic   match_all;
    flags_t ev;
    logic   rd_start, rd_end;
    logic   in_read_w;
    en_t    en_w;

    assign cur = {hr_i, min_i, sec_i};
    assign alm = {alm_hr_i, alm_min_i, alm_sec_i};

    rtc_alarm_cmp #(.W(BYTE_W), .N(N_FIELDS), .WB(WILD_W)) u_cmp (
        .cur_i (cur),
        .alm_i (alm),
        .all_o (match_all)
    );

    always_comb begin
        st_d     = st_q;
        ev.pf    = per_i;
        ev.af    = upd_i & match_all;
        ev.uf    = upd_i;
        rd_start = rd_i & ~st_q.in_read;
        rd_end   = ~rd_i & st_q.in_read;

        if (cfg_wr_i) begin
            st_d.en.pie = cfg_pie_i;
            st_d.en.aie = cfg_aie_i;
            st_d.en.uie = cfg_uie_i & ~cfg_set_i;
        end

        if (rd_start) begin
            st_d.snap    = byte_of(st_q.flags, st_q.en);
            st_d.flags   = '0;
            st_d.pend    = ev;
            st_d.in_read = 1'b1;
        end else if (st_q.in_read && rd_i) begin
            st_d.pend    = st_q.pend | ev;
        end else if (rd_end) begin
            st_d.flags   = st_q.pend | ev;
            st_d.pend    = '0;
            st_d.in_read = 1'b0;
        end else begin
            st_d.flags   = st_q.flags | ev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o   = st_q.in_read ? st_q.snap : byte_of(st_q.flags, st_q.en);
    assign irq_pull_o = req_of(st_q.flags, st_q.en);
    assign in_read_w  = st_q.in_read;
    assign en_w       = st_q.en;
endmodule

// File: rtl/rtc_irq_ctl_chk.sv
module rtc_irq_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       per_i,
    input logic       upd_i,
    input logic       rd_i,
    input logic       cfg_wr_i,
    input logic       cfg_set_i,
    input logic [7:0] status_o,
    input logic       irq_pull_o,
    input logic       in_read,
    input logic [2:0] en
);
    always_comb begin
        if (rst_n) assert_low_nibble_R1: assert (status_o[3:0] == 4'b0000);
    end

    assert_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_read |-> (irq_pull_o == ((status_o[6] & en[2]) | (status_o[5] & en[1]) | (status_o[4] & en[0])))
                     && (status_o[7] == irq_pull_o));

    assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_read && rd_i) |=> $stable(status_o));

    assert_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_read |-> !irq_pull_o);

    assert_periodic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (per_i && !rd_i && !in_read) |=> status_o[6]);

    assert_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !rd_i && !in_read) |=> status_o[4]);

    assert_set_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && cfg_set_i) |=> !en[0]);
endmodule

bind rtc_irq_ctl rtc_irq_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .per_i      (per_i),
    .upd_i      (upd_i),
    .rd_i       (rd_i),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_set_i  (cfg_set_i),
    .status_o   (status_o),
    .irq_pull_o (irq_pull_o),
    .in_read    (in_read_w),
    .en         (en_w)
);

// File: tb/tb_rtc_irq_ctl.sv
module tb_rtc_irq_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic per_i = 0, upd_i = 0, rd_i = 0;
    logic cfg_wr_i = 0, cfg_pie_i = 0, cfg_aie_i = 0, cfg_uie_i = 0, cfg_set_i = 0;
    logic [7:0] sec_i = 0, min_i = 0, hr_i = 0;
    logic [7:0] alm_sec_i = 8'h01, alm_min_i = 8'h01, alm_hr_i = 8'h01;
    logic [7:0] status_o;
    logic       irq_pull_o;
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rtc_irq_ctl dut (.*);

    // {sec, min, hr, alarm sec, alarm min, alarm hr, expected alarm flag}
    localparam logic [48:0] VEC [8] = '{
        {8'h12, 8'h34, 8'h05, 8'h12, 8'h34, 8'h05, 1'b1},
        {8'h12, 8'h34, 8'h05, 8'h13, 8'h34, 8'h05, 1'b0},
        {8'h12, 8'h34, 8'h05, 8'h12, 8'h34, 8'hC0, 1'b1},
        {8'h12, 8'h34, 8'h05, 8'h12, 8'h35, 8'hFF, 1'b0},
        {8'h59, 8'h34, 8'h05, 8'h59, 8'hD7, 8'hC3, 1'b1},
        {8'h00, 8'h00, 8'h00, 8'hFF, 8'hC0, 8'hE5, 1'b1},
        {8'h12, 8'h34, 8'h05, 8'h12, 8'h34, 8'hBF, 1'b0},
        {8'h12, 8'h34, 8'h05, 8'h12, 8'h80, 8'h05, 1'b0}
    };

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(logic p, logic a, logic u, logic s);
        cfg_pie_i = p; cfg_aie_i = a; cfg_uie_i = u; cfg_set_i = s; cfg_wr_i = 1;
        step();
        cfg_wr_i = 0;
    endtask

    task automatic pulse_per();
        per_i = 1; step(); per_i = 0;
    endtask

    task automatic pulse_upd();
        upd_i = 1; step(); upd_i = 0;
    endtask

    task automatic rd_clear(output logic [7:0] v);
        rd_i = 1; step(); v = status_o;
        step();
        rd_i = 0; step();
    endtask

    initial begin
        logic [7:0] v;
        #2;
        chk("R9 reset status", status_o, 8'h00);
        chk("R9 reset irq", {7'd0, irq_pull_o}, 8'h00);
        rst_n = 1; step();

        // R6 R7 table walk
        for (int i = 0; i < 8; i++) begin
            {sec_i, min_i, hr_i, alm_sec_i, alm_min_i, alm_hr_i} = VEC[i][48:1];
            pulse_upd();
            chk($sformatf("R6/R7 vec%0d", i), status_o, {1'b0, 1'b0, VEC[i][0], 1'b1, 4'b0});
            rd_clear(v);
        end

        // R7: matching bytes without update pulse leave the alarm flag clear
        {sec_i, min_i, hr_i, alm_sec_i, alm_min_i, alm_hr_i} = {8'h10, 8'h20, 8'h03, 8'h10, 8'h20, 8'h03};
        step(); step();
        chk("R7 no pulse no alarm", status_o, 8'h00);
        alm_sec_i = 8'h11;

        // R3 R8 flags set without enables
        pulse_per();
        chk("R8 periodic flag", status_o, 8'h40);
        chk("R3 no irq without enable", {7'd0, irq_pull_o}, 8'h00);
        pulse_upd();
        chk("R8 update flag", status_o, 8'h50);

        // R3 R2 late enable
        cfg(1, 0, 0, 0);
        chk("R3 late enable irq", {7'd0, irq_pull_o}, 8'h01);
        chk("R2 summary bit", status_o, 8'hD0);

        // R4 read captures, holds, clears, releases
        rd_i = 1; step();
        chk("R4 captured", status_o, 8'hD0);
        chk("R4 irq released", {7'd0, irq_pull_o}, 8'h00);
        pulse_per();
        chk("R4 stable during read", status_o, 8'hD0);
        rd_i = 0; step();
        chk("R5 held event after read", status_o, 8'hC0);

        // R5 event on the read's first edge
        rd_clear(v);
        chk("R4 read value", v, 8'hC0);
        chk("R4 cleared", status_o, 8'h00);
        per_i = 1; rd_i = 1; step(); per_i = 0;
        chk("R5 coincident excluded from capture", status_o, 8'h00);
        rd_i = 0; step();
        chk("R5 coincident kept", status_o, 8'hC0);
        rd_clear(v);

        // R10 set write clears update enable
        cfg(0, 0, 1, 1);
        pulse_upd();
        chk("R10 uie forced off", {irq_pull_o, status_o}, {1'b0, 8'h10});
        cfg(0, 0, 1, 0);
        chk("R2 uie on", {irq_pull_o, status_o}, {1'b1, 8'h90});

        // R2 alarm enable path
        cfg(0, 1, 0, 0);
        chk("R2 af not set so idle", {irq_pull_o, status_o}, {1'b0, 8'h10});
        alm_sec_i = 8'hC0; alm_min_i = 8'hC0; alm_hr_i = 8'hC0;
        pulse_upd();
        chk("R2 alarm irq", {irq_pull_o, status_o}, {1'b1, 8'hB0});

        // R9 reset mid-run clears flags and enables
        cfg(1, 1, 1, 0);
        rst_n = 0; #2;
        chk("R9 async clear", {irq_pull_o, status_o}, 9'h000);
        rst_n = 1; step();
        pulse_per();
        chk("R9 enables cleared", {irq_pull_o, status_o}, {1'b0, 8'h40});

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule